// File: doc/BRIEF.md
# SMBus Indexed Block-Access Configuration Register Target

This block is a serial-bus target that owns a bank of twenty-two 8-bit configuration registers for a clock-generation chip. A host on a two-wire SMBus link reaches it at the 8-bit address pair 0xD2 (write) and 0xD3 (read). Every access begins by naming a starting register index. After that, a run of consecutive registers is written or read. The register index moves up by one after each data byte. The block sees both bus lines through a two-flop synchroniser clocked by the system clock, and it pulls the data line low through an open-drain enable.

A block write has this shape: start, 0xD2, index, a byte count, then the data bytes. A block read has this shape: start, 0xD2, index, repeated start, 0xD3. On a read the target first returns the current value of the length register, which is register 8, and then returns that many data bytes. The host acknowledges every byte except the last, which it NACKs, and then sends stop. All register contents are presented in parallel to the rest of the chip. Two identity bytes cannot be changed, one register is locked against writes, and a few bits are reserved and always read 0.

Top module: `cfg_smbus_regbank`

## Requirements
- R1: After reset the registers hold these values: reg1 = 0xFF, reg2 = 0x7F, reg3 = 0x7F, reg4 = 0xFF, reg5 = 0xF5, reg6 = 0x25, reg7 = 0x01, reg8 = 0x09. Every other register holds 0x00, and SDA is released.
- R2: The target ACKs an address byte of 0xD2 or 0xD3. It ACKs no other address byte, ignores the rest of that transfer, and leaves every register unchanged.
- R3: In a write, the target ACKs the index byte, the byte-count byte and each data byte. The byte-count byte is not stored. Data byte k goes to register index+k.
- R4: After a repeated start and 0xD3, the first byte returned is the value of register 8. It is followed by that many data bytes, taken from consecutive registers starting at the index. Bytes are sent MSB first.
- R5: If the host keeps acknowledging after the counted data bytes, each further byte reads 0xFF because SDA stays released.
- R6: Registers 6 and 7 are read-only. Writes to them are ACKed and change nothing.
- R7: Bit 7 of register 2 and bit 7 of register 3 always read 0, whatever is written.
- R8: Register 21 ignores every write and keeps its value.
- R9: Writes to indices above 21 are ACKed and have no effect. Reads of those indices return 0x00.
- R10: A host NACK ends a read, and SDA stays released until the next start. A start or a stop always releases SDA on the next cycle.
- R11: The target begins pulling SDA low only while the synchronised SCL is low.
- R12: Bits [8r+7:8r] of the parallel output always show register r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| cfg_regs_o | output | 176 | All register contents; register r is in bits [8r+7:8r] |

## Verification
Some properties hold on every cycle, and the assertions check those continuously: the identity bytes never change, the reserved top bits of registers 2 and 3 stay clear, and the locked register holds its value. They also check that SDA is released right after any start or stop, and that the data line is first pulled low only while SCL is low. Other behaviour can only be shown by the bench's transfers. That covers the byte order on the wire, each ACK or NACK, the count byte sent first and how it limits the data bytes that follow, the 0xFF filler once the count is used up, the zeros returned past the last register, and the index advancing through the bank. The sweeps write every index with values computed from the index and compare both the parallel outputs and the read-back stream against a bench model.

// File: rtl/cfg_smbus_pkg.sv
package cfg_smbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK
    } phase_e;

    typedef enum logic [1:0] {
        SG_ADDR,
        SG_INDEX,
        SG_COUNT,
        SG_DATA
    } stage_e;

    // Value each register takes at reset.
    function automatic logic [7:0] reg_reset_val(input int unsigned r);
        case (r)
            1:       return 8'hFF;
            2, 3:    return 8'h7F;
            4:       return 8'hFF;
            5:       return 8'hF5;
            6:       return 8'h25;
            7:       return 8'h01;
            8:       return 8'h09;
            default: return 8'h00;
        endcase
    endfunction

    // Bits a host write may change; zero bits keep their value.
    function automatic logic [7:0] reg_wmask(input int unsigned r, input int unsigned lock_idx);
        if (r == lock_idx)      return 8'h00;
        if (r == 6 || r == 7)   return 8'h00;
        if (r == 2 || r == 3)   return 8'h7F;
        return 8'hFF;
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t s_d, s_q;

    assign scl_s     = s_q.scl_pipe[STAGES-1];
    assign sda_s     = s_q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~s_q.scl_prev;
    assign scl_fall  = ~scl_s & s_q.scl_prev;
    assign start_det = scl_s & s_q.scl_prev & s_q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & s_q.scl_prev & ~s_q.sda_prev & sda_s;

    always_comb begin
        s_d          = s_q;
        s_d.scl_pipe = {s_q.scl_pipe[STAGES-2:0], scl_i};
        s_d.sda_pipe = {s_q.sda_pipe[STAGES-2:0], sda_i};
        s_d.scl_prev = scl_s;
        s_d.sda_prev = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_smbus_pkg::*;
#(
    parameter int unsigned NUM_REGS = 22,
    parameter int unsigned LOCK_IDX = 21,
    parameter int unsigned IDX_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    logic [7:0] mem_d [NUM_REGS];
    logic [7:0] mem_q [NUM_REGS];

    always_comb begin
        for (int r = 0; r < NUM_REGS; r++) begin
            mem_d[r] = mem_q[r];
            if (wr_en && wr_idx == IDX_W'(r)) begin
                mem_d[r] = (mem_q[r] & ~reg_wmask(r, LOCK_IDX)) |
                           (wr_data  &  reg_wmask(r, LOCK_IDX));
            end
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (rd_idx == IDX_W'(r)) rd_data = mem_q[r];
        end
    end

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
            assign regs_flat[g*8 +: 8] = mem_q[g];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) mem_q[r] <= reg_reset_val(r);
        end else begin
            for (int r = 0; r < NUM_REGS; r++) mem_q[r] <= mem_d[r];
        end
    end

endmodule

// File: rtl/smb_target_fsm.sv
module smb_target_fsm
    import cfg_smbus_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h69,
    parameter int unsigned IDX_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data,
    input  logic [7:0]       bcount,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic [IDX_W-1:0] rd_idx
);

    localparam logic [7:0] ADDR_WR = {DEV_ADDR, 1'b0};
    localparam logic [7:0] ADDR_RD = {DEV_ADDR, 1'b1};

    typedef struct packed {
        phase_e           phase;
        stage_e           stage;
        logic [3:0]       bits;
        logic [7:0]       shreg;
        logic [IDX_W-1:0] idx;
        logic [7:0]       left;
        logic             oe;
        logic             go_tx;
        logic             wr_en;
        logic [IDX_W-1:0] wr_idx;
        logic [7:0]       wr_data;
    } fsm_t;

    fsm_t f_d, f_q;
    logic [IDX_W-1:0] idx_inc;
    logic [7:0]       next_tx;

    assign idx_inc = (f_q.idx == '1) ? f_q.idx : f_q.idx + 1'b1;
    assign next_tx = (f_q.left != 8'd0) ? rd_data : 8'hFF;

    assign sda_oe  = f_q.oe;
    assign wr_en   = f_q.wr_en;
    assign wr_idx  = f_q.wr_idx;
    assign wr_data = f_q.wr_data;
    assign rd_idx  = f_q.idx;

    always_comb begin
        f_d       = f_q;
        f_d.wr_en = 1'b0;
        if (start_det) begin
            f_d.phase = PH_RX;
            f_d.stage = SG_ADDR;
            f_d.bits  = 4'd0;
            f_d.oe    = 1'b0;
        end else if (stop_det) begin
            f_d.phase = PH_IDLE;
            f_d.oe    = 1'b0;
        end else begin
            case (f_q.phase)
                PH_RX: begin
                    if (scl_rise && f_q.bits < 4'd8) begin
                        f_d.shreg = {f_q.shreg[6:0], sda_s};
                        f_d.bits  = f_q.bits + 4'd1;
                    end else if (scl_fall && f_q.bits == 4'd8) begin
                        f_d.oe    = 1'b1;
                        f_d.phase = PH_RX_ACK;
                        f_d.go_tx = 1'b0;
                        case (f_q.stage)
                            SG_ADDR: begin
                                if (f_q.shreg == ADDR_WR) begin
                                    f_d.stage = SG_INDEX;
                                end else if (f_q.shreg == ADDR_RD) begin
                                    f_d.go_tx = 1'b1;
                                end else begin
                                    f_d.oe    = 1'b0;
                                    f_d.phase = PH_IDLE;
                                end
                            end
                            SG_INDEX: begin
                                f_d.idx   = IDX_W'(f_q.shreg);
                                f_d.stage = SG_COUNT;
                            end
                            SG_COUNT: f_d.stage = SG_DATA;
                            default: begin
                                f_d.wr_en   = 1'b1;
                                f_d.wr_idx  = f_q.idx;
                                f_d.wr_data = f_q.shreg;
                                f_d.idx     = idx_inc;
                            end
                        endcase
                    end
                end
                PH_RX_ACK: begin
                    if (scl_fall) begin
                        f_d.bits = 4'd0;
                        if (f_q.go_tx) begin
                            f_d.phase = PH_TX;
                            f_d.shreg = bcount;
                            f_d.left  = bcount;
                            f_d.oe    = ~bcount[7];
                        end else begin
                            f_d.phase = PH_RX;
                            f_d.oe    = 1'b0;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (f_q.bits == 4'd7) begin
                            f_d.oe    = 1'b0;
                            f_d.bits  = 4'd0;
                            f_d.phase = PH_TX_ACK;
                        end else begin
                            f_d.bits  = f_q.bits + 4'd1;
                            f_d.shreg = {f_q.shreg[6:0], 1'b0};
                            f_d.oe    = ~f_q.shreg[6];
                        end
                    end
                end
                PH_TX_ACK: begin
                    if (scl_rise && sda_s) begin
                        f_d.phase = PH_IDLE;
                    end else if (scl_fall) begin
                        f_d.phase = PH_TX;
                        f_d.bits  = 4'd0;
                        f_d.shreg = next_tx;
                        f_d.oe    = ~next_tx[7];
                        if (f_q.left != 8'd0) begin
                            f_d.left = f_q.left - 8'd1;
                            f_d.idx  = idx_inc;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q       <= '0;
            f_q.phase <= PH_IDLE;
            f_q.stage <= SG_ADDR;
        end else begin
            f_q <= f_d;
        end
    end

endmodule

// File: rtl/cfg_smbus_regbank.sv
module cfg_smbus_regbank #(
    parameter int unsigned NUM_REGS    = 22,
    parameter logic [6:0]  DEV_ADDR    = 7'h69,
    parameter int unsigned LOCK_IDX    = 21,
    parameter int unsigned BCNT_IDX    = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_regs_o
);

    localparam int unsigned IDX_W = 8;

    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data, bcount;

    assign bcount = cfg_regs_o[BCNT_IDX*8 +: 8];

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_target_fsm #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .bcount    (bcount),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx)
    );

    cfg_reg_bank #(.NUM_REGS(NUM_REGS), .LOCK_IDX(LOCK_IDX), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .regs_flat (cfg_regs_o)
    );

endmodule

// File: rtl/cfg_smbus_regbank_chk.sv
module cfg_smbus_regbank_chk #(
    parameter int unsigned NUM_REGS = 22,
    parameter int unsigned LOCK_IDX = 21
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_s,
    input logic                  start_det,
    input logic                  stop_det,
    input logic                  sda_oe,
    input logic [NUM_REGS*8-1:0] regs
);

    // R6
    id_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs[6*8 +: 8] == 8'h25 && regs[7*8 +: 8] == 8'h01);

    // R7
    rsvd_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !regs[2*8+7] && !regs[3*8+7]);

    // R8
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(regs[LOCK_IDX*8 +: 8]));

    // R10
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R11
    drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

endmodule

bind cfg_smbus_regbank cfg_smbus_regbank_chk #(
    .NUM_REGS(NUM_REGS),
    .LOCK_IDX(LOCK_IDX)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .regs      (cfg_regs_o)
);

// File: tb/cfg_smbus_regbank_tb_top.sv
module cfg_smbus_regbank_tb_top;

    localparam int N = 22;
    localparam int Q = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           scl = 1'b1;
    logic           sda_h = 1'b1;
    logic           sda_line;
    logic           sda_oe;
    logic [N*8-1:0] regs;

    int         checks = 0;
    int         errors = 0;
    logic       done = 1'b0;
    logic [7:0] exp_q [N];
    logic [7:0] wbuf [32];

    always #4 clk = ~clk;

    assign sda_line = sda_h & ~sda_oe;

    cfg_smbus_regbank dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .cfg_regs_o (regs)
    );

    function automatic logic [7:0] m_default(input int r);
        if (r == 1 || r == 4) return 8'hFF;
        if (r == 2 || r == 3) return 8'h7F;
        if (r == 5) return 8'hF5;
        if (r == 6) return 8'h25;
        if (r == 7) return 8'h01;
        if (r == 8) return 8'h09;
        return 8'h00;
    endfunction

    function automatic logic [7:0] m_mask(input int r);
        if (r == 6 || r == 7 || r == 21) return 8'h00;
        if (r == 2 || r == 3) return 8'h7F;
        return 8'hFF;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic check_port(input string tag);
        for (int r = 0; r < N; r++) chk8($sformatf("%s R12 reg%0d", tag, r), regs[r*8 +: 8], exp_q[r]);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; scl = 1'b1; tick(Q);
        sda_h = 1'b0; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        sda_h = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        sda_h = 1'b0; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(Q);
        scl = 1'b1; tick(Q);
        sda_h = 1'b1; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; tick(Q);
            scl = 1'b1; tick(2*Q);
            scl = 1'b0; tick(Q);
        end
        sda_h = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        ack = ~sda_line;
        tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic rd_byte(output logic [7:0] b, input logic last);
        b = 8'h00;
        sda_h = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            b = {b[6:0], sda_line};
            tick(Q);
            scl = 1'b0; tick(Q);
        end
        sda_h = last; tick(Q);
        scl = 1'b1; tick(2*Q);
        scl = 1'b0; tick(Q);
        sda_h = 1'b1;
    endtask

    task automatic blk_write(input logic [7:0] idx, input int n, input string tag);
        logic ack;
        bus_start();
        wr_byte(8'hD2, ack); chk8({tag, " R2 addr ack"}, {7'd0, ack}, 8'd1);
        wr_byte(idx, ack);   chk8({tag, " R3 index ack"}, {7'd0, ack}, 8'd1);
        wr_byte(8'(n), ack); chk8({tag, " R3 count ack"}, {7'd0, ack}, 8'd1);
        for (int k = 0; k < n; k++) begin
            wr_byte(wbuf[k], ack);
            chk8($sformatf("%s R3 data ack %0d", tag, k), {7'd0, ack}, 8'd1);
            if (int'(idx) + k < N)
                exp_q[int'(idx) + k] = (exp_q[int'(idx) + k] & ~m_mask(int'(idx) + k)) |
                                       (wbuf[k] & m_mask(int'(idx) + k));
        end
        bus_stop();
        tick(4);
    endtask

    task automatic blk_read(input logic [7:0] idx, input int nrd, input string tag);
        logic ack;
        logic [7:0] b, cnt, e;
        bus_start();
        wr_byte(8'hD2, ack); chk8({tag, " R2 addr ack"}, {7'd0, ack}, 8'd1);
        wr_byte(idx, ack);   chk8({tag, " R3 index ack"}, {7'd0, ack}, 8'd1);
        bus_rstart();
        wr_byte(8'hD3, ack); chk8({tag, " R2 read addr ack"}, {7'd0, ack}, 8'd1);
        cnt = exp_q[8];
        rd_byte(b, nrd == 0);
        chk8({tag, " R4 count byte"}, b, cnt);
        for (int k = 0; k < nrd; k++) begin
            rd_byte(b, k == nrd - 1);
            if (k >= int'(cnt)) e = 8'hFF;
            else if (int'(idx) + k < N) e = exp_q[int'(idx) + k];
            else e = 8'h00;
            chk8($sformatf("%s R4 R5 R9 data %0d", tag, k), b, e);
        end
        tick(Q);
        chk8({tag, " R10 released after nack"}, {7'd0, sda_oe}, 8'd0);
        bus_stop();
        tick(4);
    endtask

    initial begin
        tick(150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ack;
        for (int r = 0; r < N; r++) exp_q[r] = m_default(r);
        tick(10);
        rst_n = 1'b1;
        tick(5);

        // R1 reset contents and released line
        check_port("R1 reset");
        chk8("R1 sda released", {7'd0, sda_oe}, 8'd0);

        // R3 R7 write run from index 0
        wbuf[0] = 8'h13; wbuf[1] = 8'hA5; wbuf[2] = 8'hFF;
        wbuf[3] = 8'hFF; wbuf[4] = 8'h3C; wbuf[5] = 8'h5A;
        blk_write(8'd0, 6, "wr0");
        check_port("R3 R7 after wr0");

        // R6 identity bytes ignore writes
        wbuf[0] = 8'h11; wbuf[1] = 8'hEE; wbuf[2] = 8'hEE;
        blk_write(8'd5, 3, "wr5");
        check_port("R6 after wr5");

        // R8 R9 writes across the locked register and past the end
        wbuf[0] = 8'h44; wbuf[1] = 8'h55; wbuf[2] = 8'h66;
        wbuf[3] = 8'h77; wbuf[4] = 8'h88;
        blk_write(8'd19, 5, "wr19");
        check_port("R8 R9 after wr19");

        // R4 default count of 9, then R5 filler beyond the count
        blk_read(8'd0, 9, "rd0");
        blk_read(8'd0, 11, "rd0x");

        // R4 R9 shorter count, reading past the last register
        wbuf[0] = 8'h05;
        blk_write(8'd8, 1, "cnt5");
        blk_read(8'd20, 5, "rd20");
        blk_read(8'd19, 7, "rd19x");

        // R2 foreign address: no ack, nothing changes
        bus_start();
        wr_byte(8'hA4, ack); chk8("R2 foreign addr nack", {7'd0, ack}, 8'd0);
        wr_byte(8'd0, ack);  chk8("R2 foreign index nack", {7'd0, ack}, 8'd0);
        wr_byte(8'h01, ack); chk8("R2 foreign count nack", {7'd0, ack}, 8'd0);
        wr_byte(8'h99, ack); chk8("R2 foreign data nack", {7'd0, ack}, 8'd0);
        bus_stop();
        tick(4);
        check_port("R2 after foreign");

        // Sweep: every index written with an arithmetic pattern
        for (int k = 0; k < 24; k++) wbuf[k] = 8'((k * 37 + 11) & 8'hFF);
        blk_write(8'd0, 24, "sweep");
        check_port("R3 R6 R7 R8 sweep");
        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < 24; k++) wbuf[k] = 8'((k * 91 + 200 * pass + 3) & 8'hFF);
            blk_write(8'd0, 24, "sweep2");
            check_port("R3 sweep2");
            wbuf[0] = 8'd22;
            blk_write(8'd8, 1, "cnt22");
            blk_read(8'd0, 22, "rdall");
        end

        // R4 count of zero returns only the count byte, then filler
        wbuf[0] = 8'd0;
        blk_write(8'd8, 1, "cnt0");
        blk_read(8'd3, 2, "rdzero");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule